// File: doc/BRIEF.md
# SPI Serial Clock Generator with Even Divide Ratios

This block makes the serial clock of an SPI master from the system clock. A 16-bit divide value sets the serial clock period in system clocks. Only even ratios are used: the lowest bit of the stored value has no effect, so an odd value behaves like the even value just below it. The clock toggles once every half of the ratio, which gives a 50 percent duty cycle. A stored value of zero or one leaves no usable half period, and the serial clock then stays still.

The divide value can only be loaded while the controller enable is low. A load attempted while the controller is enabled is dropped. While no transfer is running, the serial clock sits at the level chosen by the polarity input. When a transfer starts, the half-period counter begins again from zero, so the first edge always comes one half period after the start. Each edge also raises a one-cycle strobe. One strobe marks edges that leave the idle level (leading) and the other marks edges that return to it (trailing). The shift engine uses these strobes to pick its launch and sample edges according to its clock phase.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is held, `div_q` is 0, `sclk` is low, and both strobes are low.
- R2: A load pulse on `div_we` while `ctrl_en` is low stores `div_wdata`. The stored value can be read on `div_q` from the next cycle on.
- R3: A load pulse while `ctrl_en` is high leaves `div_q` unchanged.
- R4: Let H = `div_q` >> 1, so bit 0 is ignored. During a transfer with H >= 1, `sclk` changes on the H-th rising system clock edge after `xfer_busy` and `ctrl_en` are both seen high. After that it changes every H system clocks.
- R5: When H = 0 (a divide value of 0 or 1), `sclk` never changes and neither strobe fires.
- R6: On the cycle after any cycle in which `xfer_busy` or `ctrl_en` is low, `sclk` equals the `cpol` value of that earlier cycle, and both strobes are low.
- R7: Each change of `sclk` comes with exactly one strobe, high for one cycle and aligned with the new level. `lead_stb` marks changes away from `cpol`, and `trail_stb` marks changes back to `cpol`. The first edge of a transfer is always a leading edge, and the two kinds alternate. The two strobes are never high together.
- R8: If a transfer is stopped early, `sclk` returns to its idle level. The next transfer starts counting from zero again, so its first edge again comes after H clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_en | input | 1 | Controller enable. Loads of the divide value are blocked while this is high |
| div_we | input | 1 | Load pulse for the divide value |
| div_wdata | input | 16 | New divide value |
| cpol | input | 1 | Idle level of the serial clock |
| xfer_busy | input | 1 | High while a transfer is in progress |
| div_q | output | 16 | Stored divide value |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on each leading edge |
| trail_stb | output | 1 | One-cycle strobe on each trailing edge |

## Verification
The assertions check these rules on every cycle: the lock on loads, the return of the clock to its idle level, the exclusive and edge-aligned strobes, and the silence when H is zero. The exact cycle of the first edge, the spacing for each divide value (including odd values being rounded down), the order of leading and trailing edges, and the restart after an aborted transfer depend on counting over many cycles. Only the bench scenarios can show those.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  typedef struct packed {
    logic lead;
    logic trail;
  } sclk_stb_t;
endpackage

// File: rtl/spi_sclk_divreg.sv
module spi_sclk_divreg #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [DIV_W-1:0] div_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_q <= '0;
    else if (div_we && !ctrl_en) div_q <= div_wdata;
  end

  // R3
  wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_we && ctrl_en) |=> $stable(div_q));
endmodule

// File: rtl/spi_sclk_count.sv
module spi_sclk_count #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-2:0] half,
  output logic             tick
);
  localparam int HW = DIV_W - 1;
  localparam logic [HW-1:0] ONE = {{(HW-1){1'b0}}, 1'b1};

  logic [HW-1:0] cnt;
  logic          half_ok;

  assign half_ok = (half != '0);
  assign tick    = run && half_ok && (cnt == half - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || !half_ok) cnt <= '0;
    else if (tick)             cnt <= '0;
    else                       cnt <= cnt + ONE;
  end

  // R5
  no_tick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half == '0) |-> !tick);
endmodule

// File: rtl/spi_sclk_edge.sv
module spi_sclk_edge
  import spi_sclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      cpol,
  input  logic      tick,
  output logic      sclk,
  output sclk_stb_t stb
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk  <= 1'b0;
      phase <= 1'b0;
      stb   <= '0;
    end else if (!run) begin
      sclk  <= cpol;
      phase <= 1'b0;
      stb   <= '0;
    end else begin
      stb.lead  <= tick && !phase;
      stb.trail <= tick && phase;
      if (tick) begin
        sclk  <= ~sclk;
        phase <= ~phase;
      end
    end
  end

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == $past(cpol)) && !stb.lead && !stb.trail);
  // R7
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.lead, stb.trail}));
  // R7
  stb_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.lead || stb.trail) |-> (sclk != $past(sclk)));
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             cpol,
  input  logic             xfer_busy,
  output logic [DIV_W-1:0] div_q,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  logic      run;
  logic      tick;
  sclk_stb_t stb;

  assign run = ctrl_en && xfer_busy;

  spi_sclk_divreg #(.DIV_W(DIV_W)) u_divreg (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .div_we(div_we),
    .div_wdata(div_wdata), .div_q(div_q));

  spi_sclk_count #(.DIV_W(DIV_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run), .half(div_q[DIV_W-1:1]),
    .tick(tick));

  spi_sclk_edge u_edge (
    .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol), .tick(tick),
    .sclk(sclk), .stb(stb));

  assign lead_stb  = stb.lead;
  assign trail_stb = stb.trail;

  // R5
  silent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q[DIV_W-1:1] == '0) |=> !lead_stb && !trail_stb);
endmodule

// File: tb/spi_sclk_gen_tb.sv
module spi_sclk_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {divide value, cpol, expected half period}
  localparam logic [32:0] VEC [NV] = '{
    {16'd2,   1'b0, 16'd1},
    {16'd3,   1'b1, 16'd1},
    {16'd4,   1'b0, 16'd2},
    {16'd7,   1'b1, 16'd3},
    {16'd10,  1'b0, 16'd5},
    {16'd257, 1'b1, 16'd128},
    {16'd0,   1'b0, 16'd0},
    {16'd1,   1'b1, 16'd0}
  };

  logic clk = 0, rst_n = 0, ctrl_en = 0, div_we = 0, cpol = 0, xfer_busy = 0;
  logic [15:0] div_wdata = '0;
  logic [15:0] div_q;
  logic sclk, lead_stb, trail_stb;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .div_we(div_we),
    .div_wdata(div_wdata), .cpol(cpol), .xfer_busy(xfer_busy),
    .div_q(div_q), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk); div_we = 1; div_wdata = v;
    @(negedge clk); div_we = 0;
  endtask

  // Runs a transfer for win cycles; returns the first lead and trail times.
  task automatic measure(input int win, output int fl, output int ft,
                         output int nl, output int nt, output bit lvl_ok);
    fl = -1; ft = -1; nl = 0; nt = 0; lvl_ok = 1;
    @(negedge clk); xfer_busy = 1;
    for (int k = 1; k <= win; k++) begin
      @(negedge clk);
      if (lead_stb) begin
        nl++; if (fl < 0) fl = k;
        if (sclk == cpol) lvl_ok = 0;
      end
      if (trail_stb) begin
        nt++; if (ft < 0) ft = k;
        if (sclk != cpol) lvl_ok = 0;
      end
      if (lead_stb && trail_stb) lvl_ok = 0;
    end
    xfer_busy = 0;
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int fl, ft, nl, nt, h, win;
    bit lv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(div_q == 0, "R1 div_q", div_q, 0);
    chk(sclk == 0 && !lead_stb && !trail_stb, "R1 outputs", {sclk, lead_stb, trail_stb}, 0);
    rst_n = 1;

    // table walk: R2 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      ctrl_en = 0;
      load(VEC[i][32:17]);
      chk(div_q == VEC[i][32:17], "R2 load", div_q, VEC[i][32:17]);
      cpol = VEC[i][16];
      h = VEC[i][15:0];
      ctrl_en = 1;
      @(negedge clk);
      chk(sclk == cpol, "R6 idle before start", sclk, cpol);
      win = (h == 0) ? 40 : 4 * h;
      measure(win, fl, ft, nl, nt, lv);
      if (h == 0) begin
        chk(nl == 0 && nt == 0, "R5 no strobes", nl + nt, 0);
      end else begin
        chk(fl == h, "R4 first edge", fl, h);
        chk(ft == 2 * h, "R4 second edge", ft, 2 * h);
        chk(nl == 2 && nt == 2, "R7 strobe count", nl * 10 + nt, 22);
      end
      chk(lv, "R7 strobe level", lv, 1);
      @(negedge clk);
      chk(sclk == cpol && !lead_stb && !trail_stb, "R6 idle after", sclk, cpol);
    end

    // R3 load while enabled is dropped
    ctrl_en = 0; load(16'd8);
    ctrl_en = 1; load(16'd32);
    chk(div_q == 16'd8, "R3 locked", div_q, 8);

    // R6 idle level follows cpol
    cpol = 1; @(negedge clk);
    chk(sclk == 1, "R6 cpol high", sclk, 1);
    cpol = 0; @(negedge clk);
    chk(sclk == 0, "R6 cpol low", sclk, 0);

    // R8 abort after first edge, then restart
    measure(6, fl, ft, nl, nt, lv);
    chk(fl == 4 && ft == -1, "R8 pre-abort edge", fl, 4);
    @(negedge clk);
    chk(sclk == cpol && !lead_stb && !trail_stb, "R8 abort idle", sclk, cpol);
    measure(8, fl, ft, nl, nt, lv);
    chk(fl == 4 && ft == 8, "R8 restart first edge", fl, 4);

    // R6 disabling the controller mid transfer idles the clock
    @(negedge clk); xfer_busy = 1;
    repeat (5) @(negedge clk);
    ctrl_en = 0;
    @(negedge clk);
    chk(sclk == cpol && !lead_stb && !trail_stb, "R6 enable drop", sclk, cpol);
    xfer_busy = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule